// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps speculative results in program order between dispatch and architectural update. Each dispatched instruction claims the slot at the tail of a circular buffer and receives that slot's tag. Execution units later broadcast results out of order on either of two result buses. A broadcast is matched by tag and marks the slot finished. The oldest slots leave from the head, strictly in order, at up to two per clock. Retirement writes registers, writes memory for stores, or discards all speculative state and steers fetch to the right address when a branch was guessed wrong. Faults noted during execution stay attached to their slot and are raised only when that slot becomes the oldest.

A rename table maps each architectural register to the youngest uncommitted slot that will write it. A lookup port turns a source register into a pending flag, the producing tag and, once that producer has finished, its value. Dispatch stalls while all slots are held or while a flush is being raised.

Top module: `reorder_buffer`

## Requirements
- R1: Allocation hands out the tail tag and steps it by one, modulo the depth. With all 8 slots held, `alloc_ready` is low and `alloc_valid` has no effect, so the next tag handed out is unchanged.
- R2: A broadcast on either result port whose tag names a held slot marks that slot finished. Both ports may write in the same cycle. A broadcast naming a free slot is ignored, and a slot allocated later with that tag still reads as not finished.
- R3: Nothing retires while the head slot is unfinished, even when younger slots have finished.
- R4: When the head slot and the slot after it are both finished and eligible, both retire in the same cycle. The older one appears on slot-0 outputs and the younger on slot-1 outputs.
- R5: The kind code at allocation is 0 for a register result, 1 for a store and 2 for a branch. A retiring register-kind slot asserts its write-valid output with its destination register and its broadcast value.
- R6: A retiring store asserts `mem_valid`, with the broadcast aux field as `mem_addr` and the broadcast value as `mem_data`. Only one store retires per cycle, so a store directly behind a retiring store waits one cycle.
- R7: A finished branch without the mispredict flag retires with no write. A finished branch at the head with the mispredict flag asserts `flush` and `redirect_valid`, with its aux field on `redirect_target`. No write happens in that cycle, every slot is discarded, and the next tag handed out is 0.
- R8: A result carrying the fault flag raises nothing until its slot is the head. Older slots retire normally before it. At the head, the slot asserts `exc_valid` with `exc_tag` equal to its tag, asserts `flush`, and retires nothing. Afterwards the buffer is empty.
- R9: The lookup port reports, for a register, whether an uncommitted producer exists, that producer's tag, and once it has finished, its value with `lk_ready` high.
- R10: Retiring a register-kind slot clears the register's pending mark only if the rename table still names that slot. A register with a younger producer stays pending on the younger tag.
- R11: During a flush cycle `alloc_ready` is low and an allocation request is dropped.
- R12: After reset the buffer is empty, `alloc_ready` is high, the tag offered is 0, no register is pending and no retirement output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_kind | input | 2 | 0 register, 1 store, 2 branch |
| alloc_dest | input | REG_W (3) | Destination register for register kind |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W (3) | Tag of the slot being offered |
| wb0_valid | input | 1 | Result port 0 strobe |
| wb0_tag | input | TAG_W (3) | Result port 0 target slot |
| wb0_value | input | DATA_W (32) | Result value or store data |
| wb0_aux | input | DATA_W (32) | Store address or branch target |
| wb0_exc | input | 1 | Execution raised a fault |
| wb0_mispred | input | 1 | Branch was mispredicted |
| wb1_valid | input | 1 | Result port 1 strobe |
| wb1_tag | input | TAG_W (3) | Result port 1 target slot |
| wb1_value | input | DATA_W (32) | Result value or store data |
| wb1_aux | input | DATA_W (32) | Store address or branch target |
| wb1_exc | input | 1 | Execution raised a fault |
| wb1_mispred | input | 1 | Branch was mispredicted |
| lk_reg | input | REG_W (3) | Register to look up |
| lk_pending | output | 1 | Register has an uncommitted producer |
| lk_tag | output | TAG_W (3) | Tag of that producer |
| lk_ready | output | 1 | Producer has finished |
| lk_value | output | DATA_W (32) | Producer's value |
| cw0_valid | output | 1 | Older retiring register write |
| cw0_reg | output | REG_W (3) | Its register |
| cw0_value | output | DATA_W (32) | Its value |
| cw1_valid | output | 1 | Younger retiring register write |
| cw1_reg | output | REG_W (3) | Its register |
| cw1_value | output | DATA_W (32) | Its value |
| mem_valid | output | 1 | Store retires |
| mem_addr | output | DATA_W (32) | Store address |
| mem_data | output | DATA_W (32) | Store data |
| flush | output | 1 | All slots discarded this cycle |
| redirect_valid | output | 1 | Mispredicted branch retires |
| redirect_target | output | DATA_W (32) | Correct fetch address |
| exc_valid | output | 1 | Fault taken at head |
| exc_tag | output | TAG_W (3) | Tag of the faulting slot |

## Verification
The bench builds the block with its defaults: 8 slots, 8 architectural registers and 32-bit data. With 8 slots the bench can fill the buffer from every occupancy from one to full. Results arrive youngest first on both ports, and the retirement pairs are counted out arithmetically. Across the sweep the tail wraps several times. With only 8 registers, every register can be named in a round and the rename table can be aliased on purpose. The directed stores, branches and faults that follow begin from the wrapped pointer positions the sweep leaves behind.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        OP_REG    = 2'd0,
        OP_STORE  = 2'd1,
        OP_BRANCH = 2'd2
    } op_kind_e;

    typedef struct packed {
        logic     valid;
        logic     done;
        logic     exc;
        logic     mispred;
        op_kind_e kind;
    } rob_flags_t;

    // finished and carries a fault
    function automatic logic traps(rob_flags_t f);
        return f.valid && f.done && f.exc;
    endfunction

    // finished branch that went the wrong way, with no fault
    function automatic logic redirects(rob_flags_t f);
        return f.valid && f.done && !f.exc && f.kind == OP_BRANCH && f.mispred;
    endfunction

    // finished and may leave without disturbing the pipeline
    function automatic logic clean(rob_flags_t f);
        return f.valid && f.done && !traps(f) && !redirects(f);
    endfunction

endpackage

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 3,
    parameter int unsigned TAG_W  = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              flush,
    input  logic                              alloc_fire,
    input  logic [TAG_W-1:0]                  alloc_tag,
    input  op_kind_e                          alloc_kind,
    input  logic [REG_W-1:0]                  alloc_dest,
    input  logic [1:0]                        wb_valid,
    input  logic [1:0][TAG_W-1:0]             wb_tag,
    input  logic [1:0][DATA_W-1:0]            wb_value,
    input  logic [1:0][DATA_W-1:0]            wb_aux,
    input  logic [1:0]                        wb_exc,
    input  logic [1:0]                        wb_mispred,
    input  logic [TAG_W-1:0]                  head,
    input  logic [1:0]                        nretire,
    output rob_flags_t [DEPTH-1:0]            flags,
    output logic [DEPTH-1:0][REG_W-1:0]       dest,
    output logic [DEPTH-1:0][DATA_W-1:0]      value,
    output logic [DEPTH-1:0][DATA_W-1:0]      aux
);
    localparam logic [TAG_W-1:0] STEP = TAG_W'(1);

    rob_flags_t [DEPTH-1:0]       flags_q;
    logic [DEPTH-1:0][REG_W-1:0]  dest_q;
    logic [DEPTH-1:0][DATA_W-1:0] value_q;
    logic [DEPTH-1:0][DATA_W-1:0] aux_q;
    logic [DEPTH-1:0]             retire_mask;
    logic [TAG_W-1:0]             head_next;

    assign head_next = head + STEP;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            retire_mask[i] = (nretire != 2'd0 && head == TAG_W'(i)) ||
                             (nretire == 2'd2 && head_next == TAG_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            flags_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (retire_mask[i]) flags_q[i].valid <= 1'b0;
            end
            for (int p = 0; p < 2; p++) begin
                if (wb_valid[p] && flags_q[wb_tag[p]].valid) begin
                    flags_q[wb_tag[p]].done    <= 1'b1;
                    flags_q[wb_tag[p]].exc     <= wb_exc[p];
                    flags_q[wb_tag[p]].mispred <= wb_mispred[p];
                end
            end
            if (alloc_fire) begin
                flags_q[alloc_tag] <= '{valid: 1'b1, done: 1'b0, exc: 1'b0,
                                        mispred: 1'b0, kind: alloc_kind};
            end
        end
    end

    // payload needs no reset: it is only read behind a valid, done slot
    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (wb_valid[p] && flags_q[wb_tag[p]].valid) begin
                value_q[wb_tag[p]] <= wb_value[p];
                aux_q[wb_tag[p]]   <= wb_aux[p];
            end
        end
        if (alloc_fire) dest_q[alloc_tag] <= alloc_dest;
    end

    assign flags = flags_q;
    assign dest  = dest_q;
    assign value = value_q;
    assign aux   = aux_q;
endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned REG_W  = 3,
    parameter int unsigned TAG_W  = $clog2(DEPTH)
) (
    input  logic [TAG_W-1:0]                 head,
    input  logic [TAG_W:0]                   count,
    input  rob_flags_t [DEPTH-1:0]           flags,
    input  logic [DEPTH-1:0][REG_W-1:0]      dest,
    input  logic [DEPTH-1:0][DATA_W-1:0]     value,
    input  logic [DEPTH-1:0][DATA_W-1:0]     aux,
    output logic [1:0]                       nretire,
    output logic                             cw0_valid,
    output logic [REG_W-1:0]                 cw0_reg,
    output logic [DATA_W-1:0]                cw0_value,
    output logic                             cw1_valid,
    output logic [REG_W-1:0]                 cw1_reg,
    output logic [DATA_W-1:0]                cw1_value,
    output logic                             mem_valid,
    output logic [DATA_W-1:0]                mem_addr,
    output logic [DATA_W-1:0]                mem_data,
    output logic                             flush,
    output logic                             redirect_valid,
    output logic [DATA_W-1:0]                redirect_target,
    output logic                             exc_valid,
    output logic [TAG_W-1:0]                 exc_tag
);
    localparam logic [TAG_W-1:0] STEP = TAG_W'(1);

    logic [TAG_W-1:0] h0, h1;
    rob_flags_t       f0, f1;
    logic             have0, have1, ok0, ok1, store0, store1;

    assign h0 = head;
    assign h1 = head + STEP;
    assign f0 = flags[h0];
    assign f1 = flags[h1];

    always_comb begin
        have0  = count != '0;
        have1  = count > (TAG_W+1)'(1);
        store0 = f0.kind == OP_STORE;
        store1 = f1.kind == OP_STORE;
        ok0    = have0 && clean(f0);
        ok1    = ok0 && have1 && clean(f1) && !(store0 && store1);

        nretire = {1'b0, ok0} + {1'b0, ok1};

        exc_valid       = have0 && traps(f0);
        exc_tag         = h0;
        redirect_valid  = have0 && redirects(f0);
        redirect_target = aux[h0];
        flush           = exc_valid || redirect_valid;

        cw0_valid = ok0 && f0.kind == OP_REG;
        cw0_reg   = dest[h0];
        cw0_value = value[h0];
        cw1_valid = ok1 && f1.kind == OP_REG;
        cw1_reg   = dest[h1];
        cw1_value = value[h1];

        mem_valid = (ok0 && store0) || (ok1 && store1);
        if (ok0 && store0) begin
            mem_addr = aux[h0];
            mem_data = value[h0];
        end else begin
            mem_addr = aux[h1];
            mem_data = value[h1];
        end
    end
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
    parameter int unsigned NREGS = 8,
    parameter int unsigned REG_W = $clog2(NREGS),
    parameter int unsigned TAG_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       set_valid,
    input  logic [REG_W-1:0]           set_reg,
    input  logic [TAG_W-1:0]           set_tag,
    input  logic [1:0]                 clr_valid,
    input  logic [1:0][REG_W-1:0]      clr_reg,
    input  logic [1:0][TAG_W-1:0]      clr_tag,
    input  logic [REG_W-1:0]           lk_reg,
    output logic                       lk_pending,
    output logic [TAG_W-1:0]           lk_tag
);
    logic [NREGS-1:0]            busy_q;
    logic [NREGS-1:0][TAG_W-1:0] tag_q;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        logic hit0, hit1, take;
        assign hit0 = clr_valid[0] && clr_reg[0] == REG_W'(r) && clr_tag[0] == tag_q[r];
        assign hit1 = clr_valid[1] && clr_reg[1] == REG_W'(r) && clr_tag[1] == tag_q[r];
        assign take = set_valid && set_reg == REG_W'(r);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                busy_q[r] <= 1'b0;
                tag_q[r]  <= '0;
            end else if (take) begin
                busy_q[r] <= 1'b1;
                tag_q[r]  <= set_tag;
            end else if (hit0 || hit1) begin
                busy_q[r] <= 1'b0;
            end
        end
    end

    assign lk_pending = busy_q[lk_reg];
    assign lk_tag     = tag_q[lk_reg];
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREGS  = 8,
    localparam int unsigned TAG_W = $clog2(DEPTH),
    localparam int unsigned REG_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [REG_W-1:0]  alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb0_valid,
    input  logic [TAG_W-1:0]  wb0_tag,
    input  logic [DATA_W-1:0] wb0_value,
    input  logic [DATA_W-1:0] wb0_aux,
    input  logic              wb0_exc,
    input  logic              wb0_mispred,
    input  logic              wb1_valid,
    input  logic [TAG_W-1:0]  wb1_tag,
    input  logic [DATA_W-1:0] wb1_value,
    input  logic [DATA_W-1:0] wb1_aux,
    input  logic              wb1_exc,
    input  logic              wb1_mispred,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_pending,
    output logic [TAG_W-1:0]  lk_tag,
    output logic              lk_ready,
    output logic [DATA_W-1:0] lk_value,
    output logic              cw0_valid,
    output logic [REG_W-1:0]  cw0_reg,
    output logic [DATA_W-1:0] cw0_value,
    output logic              cw1_valid,
    output logic [REG_W-1:0]  cw1_reg,
    output logic [DATA_W-1:0] cw1_value,
    output logic              mem_valid,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              flush,
    output logic              redirect_valid,
    output logic [DATA_W-1:0] redirect_target,
    output logic              exc_valid,
    output logic [TAG_W-1:0]  exc_tag
);
    localparam int unsigned   CNT_W = TAG_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [TAG_W-1:0] STEP = TAG_W'(1);

    logic [TAG_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    logic             alloc_fire;
    logic [1:0]       nretire;
    op_kind_e         kind_in;

    rob_flags_t [DEPTH-1:0]       flags;
    logic [DEPTH-1:0][REG_W-1:0]  dest;
    logic [DEPTH-1:0][DATA_W-1:0] value;
    logic [DEPTH-1:0][DATA_W-1:0] aux;

    assign kind_in     = op_kind_e'(alloc_kind);
    assign alloc_ready = count_q != FULL && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_q + TAG_W'(nretire);
            tail_q  <= tail_q + (alloc_fire ? STEP : '0);
            count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(nretire);
        end
    end

    rob_store #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .TAG_W(TAG_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .alloc_fire (alloc_fire),
        .alloc_tag  (tail_q),
        .alloc_kind (kind_in),
        .alloc_dest (alloc_dest),
        .wb_valid   ({wb1_valid, wb0_valid}),
        .wb_tag     ({wb1_tag, wb0_tag}),
        .wb_value   ({wb1_value, wb0_value}),
        .wb_aux     ({wb1_aux, wb0_aux}),
        .wb_exc     ({wb1_exc, wb0_exc}),
        .wb_mispred ({wb1_mispred, wb0_mispred}),
        .head       (head_q),
        .nretire    (nretire),
        .flags      (flags),
        .dest       (dest),
        .value      (value),
        .aux        (aux)
    );

    rob_retire #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .TAG_W(TAG_W)
    ) u_retire (
        .head            (head_q),
        .count           (count_q),
        .flags           (flags),
        .dest            (dest),
        .value           (value),
        .aux             (aux),
        .nretire         (nretire),
        .cw0_valid       (cw0_valid),
        .cw0_reg         (cw0_reg),
        .cw0_value       (cw0_value),
        .cw1_valid       (cw1_valid),
        .cw1_reg         (cw1_reg),
        .cw1_value       (cw1_value),
        .mem_valid       (mem_valid),
        .mem_addr        (mem_addr),
        .mem_data        (mem_data),
        .flush           (flush),
        .redirect_valid  (redirect_valid),
        .redirect_target (redirect_target),
        .exc_valid       (exc_valid),
        .exc_tag         (exc_tag)
    );

    rob_rename #(
        .NREGS(NREGS), .REG_W(REG_W), .TAG_W(TAG_W)
    ) u_rename (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .set_valid  (alloc_fire && kind_in == OP_REG),
        .set_reg    (alloc_dest),
        .set_tag    (tail_q),
        .clr_valid  ({cw1_valid, cw0_valid}),
        .clr_reg    ({cw1_reg, cw0_reg}),
        .clr_tag    ({head_q + STEP, head_q}),
        .lk_reg     (lk_reg),
        .lk_pending (lk_pending),
        .lk_tag     (lk_tag)
    );

    assign lk_ready = lk_pending && flags[lk_tag].valid && flags[lk_tag].done;
    assign lk_value = value[lk_tag];
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned TAG_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [TAG_W:0]   count,
    input logic [TAG_W-1:0] head,
    input logic [TAG_W-1:0] tail,
    input logic             alloc_fire,
    input logic [1:0]       nretire,
    input logic             flush
);
    logic [TAG_W-1:0] span;
    assign span = tail - head;

    // R1: occupancy never exceeds the slot count
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= (TAG_W+1)'(DEPTH));

    // R1: the distance between pointers agrees with the occupancy
    a_r1_ptr_span: assert property (@(posedge clk) disable iff (rst)
        span == count[TAG_W-1:0]);

    // R1: a full buffer takes no allocation
    a_r1_full_blocks: assert property (@(posedge clk) disable iff (rst)
        count == (TAG_W+1)'(DEPTH) |-> !alloc_fire);

    // R4: never retire more slots than are held
    a_r4_retire_limit: assert property (@(posedge clk) disable iff (rst)
        (TAG_W+1)'(nretire) <= count);

    // R7: a flush leaves the buffer empty with both pointers at zero
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == '0 && head == '0 && tail == '0);
endmodule

bind reorder_buffer rob_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .count      (count_q),
    .head       (head_q),
    .tail       (tail_q),
    .alloc_fire (alloc_fire),
    .nretire    (nretire),
    .flush      (flush)
);

// File: tb/sim_reorder_buffer.sv
module sim_reorder_buffer;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        alloc_valid = 0;
    logic [1:0]  alloc_kind = 0;
    logic [2:0]  alloc_dest = 0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        wb0_valid = 0, wb0_exc = 0, wb0_mispred = 0;
    logic [2:0]  wb0_tag = 0;
    logic [31:0] wb0_value = 0, wb0_aux = 0;
    logic        wb1_valid = 0, wb1_exc = 0, wb1_mispred = 0;
    logic [2:0]  wb1_tag = 0;
    logic [31:0] wb1_value = 0, wb1_aux = 0;
    logic [2:0]  lk_reg = 0;
    logic        lk_pending, lk_ready;
    logic [2:0]  lk_tag;
    logic [31:0] lk_value;
    logic        cw0_valid, cw1_valid;
    logic [2:0]  cw0_reg, cw1_reg;
    logic [31:0] cw0_value, cw1_value;
    logic        mem_valid;
    logic [31:0] mem_addr, mem_data;
    logic        flush, redirect_valid, exc_valid;
    logic [31:0] redirect_target;
    logic [2:0]  exc_tag;

    reorder_buffer u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(input logic [1:0] k, input logic [2:0] d);
        alloc_valid = 1; alloc_kind = k; alloc_dest = d;
        tick();
        alloc_valid = 0;
    endtask

    task automatic put0(input int t, input logic [31:0] v, input logic [31:0] a,
                        input logic e, input logic m);
        wb0_valid = 1; wb0_tag = 3'(t); wb0_value = v; wb0_aux = a;
        wb0_exc = e; wb0_mispred = m;
    endtask

    task automatic put1(input int t, input logic [31:0] v, input logic [31:0] a,
                        input logic e, input logic m);
        wb1_valid = 1; wb1_tag = 3'(t); wb1_value = v; wb1_aux = a;
        wb1_exc = e; wb1_mispred = m;
    endtask

    task automatic wb_tick();
        tick();
        wb0_valid = 0; wb1_valid = 0; wb0_exc = 0; wb1_exc = 0;
        wb0_mispred = 0; wb1_mispred = 0;
    endtask

    function automatic logic [31:0] val(input int n, input int i);
        return 32'(n * 64 + i * 5 + 3);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int tail_e;
        repeat (3) tick();
        rst = 0;
        #1;

        // R12 reset state
        chk("R12 alloc_ready", 32'(alloc_ready), 1);
        chk("R12 alloc_tag", 32'(alloc_tag), 0);
        chk("R12 cw0_valid", 32'(cw0_valid), 0);
        chk("R12 mem_valid", 32'(mem_valid), 0);
        chk("R12 flush", 32'(flush), 0);
        chk("R12 lk_pending", 32'(lk_pending), 0);

        // sweep over every occupancy, results arriving youngest first
        tail_e = 0;
        for (int n = 1; n <= 8; n++) begin
            for (int i = 0; i < n; i++) begin
                chk("R1 alloc tag", 32'(alloc_tag), 32'((tail_e + i) % 8));
                do_alloc(2'd0, 3'(i));
            end
            if (n == 8) begin
                chk("R1 full stall", 32'(alloc_ready), 0);
                do_alloc(2'd0, 3'd0);
                chk("R1 ignored alloc", 32'(alloc_tag), 32'(tail_e));
            end
            for (int i = 0; i < n; i++) begin
                lk_reg = 3'(i); #1;
                chk("R9 pending", 32'(lk_pending), 1);
                chk("R9 tag", 32'(lk_tag), 32'((tail_e + i) % 8));
                chk("R9 not ready", 32'(lk_ready), 0);
            end
            for (int j = n - 1; j >= 0; j -= 2) begin
                chk("R3 head waits", 32'(cw0_valid), 0);
                put0((tail_e + j) % 8, val(n, j), 0, 0, 0);
                if (j >= 1) put1((tail_e + j - 1) % 8, val(n, j - 1), 0, 0, 0);
                wb_tick();
            end
            lk_reg = 3'(n - 1); #1;
            chk("R9 ready", 32'(lk_ready), 1);
            chk("R9 value", lk_value, val(n, n - 1));
            for (int e = 0; e < n; e += 2) begin
                chk("R5 cw0_valid", 32'(cw0_valid), 1);
                chk("R5 cw0_reg", 32'(cw0_reg), 32'(e));
                chk("R5 cw0_value", cw0_value, val(n, e));
                if (e + 1 < n) begin
                    chk("R4 cw1_valid", 32'(cw1_valid), 1);
                    chk("R4 cw1_value", cw1_value, val(n, e + 1));
                end else begin
                    chk("R4 cw1 idle", 32'(cw1_valid), 0);
                end
                tick();
            end
            lk_reg = 3'd0; #1;
            chk("R10 cleared", 32'(lk_pending), 0);
            tail_e = (tail_e + n) % 8;
            chk("R1 tail after round", 32'(alloc_tag), 32'(tail_e));
        end

        // R6 stores: tags 4,5 stores, tag 6 register 5
        do_alloc(2'd1, 3'd0);
        do_alloc(2'd1, 3'd0);
        do_alloc(2'd0, 3'd5);
        put0(4, 32'hA0, 32'h100, 0, 0);
        put1(5, 32'hA1, 32'h104, 0, 0);
        wb_tick();
        chk("R6 mem_valid", 32'(mem_valid), 1);
        chk("R6 mem_addr", mem_addr, 32'h100);
        chk("R6 mem_data", mem_data, 32'hA0);
        chk("R6 second store waits", 32'(cw1_valid), 0);
        put0(6, 32'h55, 0, 0, 0);
        wb_tick();
        chk("R6 mem_addr 2", mem_addr, 32'h104);
        chk("R6 mem_data 2", mem_data, 32'hA1);
        chk("R6 cw1 beside store", 32'(cw1_valid), 1);
        chk("R6 cw1_reg", 32'(cw1_reg), 5);
        chk("R6 cw1_value", cw1_value, 32'h55);
        tick();
        chk("R6 mem idle", 32'(mem_valid), 0);

        // R7 / R10 / R11: tags 7(reg2) 0(branch) 1(reg3) 2(reg2)
        do_alloc(2'd0, 3'd2);
        do_alloc(2'd2, 3'd0);
        do_alloc(2'd0, 3'd3);
        do_alloc(2'd0, 3'd2);
        lk_reg = 3'd2; #1;
        chk("R10 younger tag", 32'(lk_tag), 2);
        put0(7, 32'h7, 0, 0, 0);
        put1(1, 32'h9, 0, 0, 0);
        wb_tick();
        chk("R4 cw0 head", 32'(cw0_valid), 1);
        chk("R4 cw0 value", cw0_value, 32'h7);
        chk("R4 cw1 blocked", 32'(cw1_valid), 0);
        tick();
        chk("R10 still pending", 32'(lk_pending), 1);
        chk("R10 still younger", 32'(lk_tag), 2);
        put0(0, 0, 32'h300, 0, 0);
        wb_tick();
        chk("R7 good branch no cw0", 32'(cw0_valid), 0);
        chk("R7 good branch no redirect", 32'(redirect_valid), 0);
        chk("R7 cw1 after branch", 32'(cw1_valid), 1);
        chk("R7 cw1_value", cw1_value, 32'h9);
        tick();
        chk("R1 tag e", 32'(alloc_tag), 3);
        do_alloc(2'd2, 3'd0);
        do_alloc(2'd0, 3'd4);
        put0(2, 32'h22, 0, 0, 0);
        put1(4, 32'h1, 0, 0, 0);
        wb_tick();
        chk("R5 cw0 reg2", 32'(cw0_reg), 2);
        chk("R5 cw0 value", cw0_value, 32'h22);
        put0(3, 0, 32'h400, 0, 1);
        wb_tick();
        chk("R10 matching clear", 32'(lk_pending), 0);
        chk("R7 flush", 32'(flush), 1);
        chk("R7 redirect", 32'(redirect_valid), 1);
        chk("R7 target", redirect_target, 32'h400);
        chk("R7 no cw0", 32'(cw0_valid), 0);
        chk("R7 no cw1", 32'(cw1_valid), 0);
        chk("R11 alloc blocked", 32'(alloc_ready), 0);
        do_alloc(2'd0, 3'd6);
        chk("R7 flush gone", 32'(flush), 0);
        chk("R11 tag back to 0", 32'(alloc_tag), 0);
        lk_reg = 3'd4; #1;
        chk("R7 discarded reg4", 32'(lk_pending), 0);
        lk_reg = 3'd6; #1;
        chk("R11 dropped alloc", 32'(lk_pending), 0);

        // R8 deferred fault: tags 0(reg1) 1(reg6, fault) 2(reg7)
        tick();
        do_alloc(2'd0, 3'd1);
        do_alloc(2'd0, 3'd6);
        do_alloc(2'd0, 3'd7);
        put0(1, 0, 0, 1, 0);
        put1(2, 32'h3, 0, 0, 0);
        wb_tick();
        chk("R8 not yet", 32'(exc_valid), 0);
        chk("R8 no flush yet", 32'(flush), 0);
        chk("R3 head undone", 32'(cw0_valid), 0);
        put0(0, 32'h11, 0, 0, 0);
        wb_tick();
        chk("R8 older retires", 32'(cw0_valid), 1);
        chk("R8 older value", cw0_value, 32'h11);
        chk("R8 faulting held", 32'(cw1_valid), 0);
        chk("R8 still quiet", 32'(exc_valid), 0);
        tick();
        chk("R8 exc_valid", 32'(exc_valid), 1);
        chk("R8 exc_tag", 32'(exc_tag), 1);
        chk("R8 flush", 32'(flush), 1);
        chk("R8 no write", 32'(cw0_valid), 0);
        tick();
        chk("R8 empty after", 32'(alloc_tag), 0);
        lk_reg = 3'd7; #1;
        chk("R8 younger discarded", 32'(lk_pending), 0);

        // R2 stray broadcast to a free slot
        tick();
        put1(0, 32'h99, 0, 0, 0);
        wb_tick();
        do_alloc(2'd0, 3'd0);
        lk_reg = 3'd0; #1;
        chk("R2 stray ignored", 32'(lk_ready), 0);
        put0(0, 32'h1, 0, 0, 0);
        wb_tick();
        chk("R2 captured", 32'(cw0_valid), 1);
        chk("R2 value", cw0_value, 32'h1);
        tick();

        summary();
        $finish;
    end
endmodule